// File: doc/BRIEF.md
# Bus Monitor Address Filter and Terminal Arbiter

This block sits behind a dual-bus command decoder in a combined monitor and remote-terminal device. Each validated command word arrives with a strobe, a tag that names the bus it came on, and a marker that shows whether it is the transmit half of a terminal-to-terminal pair. From these words the block decides whether the monitor captures the message, whether the co-resident responding terminal owns the bus instead, and which classification flags go with the message.

The address filter works in one of two modes. In the first, every address is watched. In the second, only the addresses enabled in a 32-bit mask are watched. Address 31 can be treated as a broadcast address. The co-resident terminal always has priority over the monitor, on either bus. The block also decodes mode codes and the expected data word count according to the selected protocol revision, and it supplies the response time-out limit for that revision. A message-end pulse from the decoder returns the block to idle.

Top module: `mon_addr_filter`

## Requirements
- R1: With `sel_only`=0, a first command (`cmd_pair`=0) whose address (bits 15..11) is not the terminal address sets `capture` on the next cycle.
- R2: With `sel_only`=1, a non-broadcast first command to address n sets `capture` only if bit n of {`filt_hi`,`filt_lo`} is 1. `filt_hi` bit k covers address 16+k and `filt_lo` bit k covers address k. Otherwise `capture` is 0 on the next cycle.
- R3: With `bcast_en`=1, address 31 is broadcast. Such a command sets `bcast` and is captured whatever the mask holds. With `bcast_en`=0, address 31 is filtered like any other address and `bcast` stays 0.
- R4: When `rt_en`=1, a first command to `rt_addr` (other than a broadcast) is never captured. It sets `yield_rt`, clears `capture` and aborts any capture in progress, whichever bus it arrives on.
- R5: While `yield_rt`=1, further commands on either bus are ignored. `yield_rt` stays 1, `capture` stays 0 and the flags keep their values.
- R6: A pair command (`cmd_pair`=1) that arrives while `capture`=1 sets `rt2rt` and stores the word on `cmd_tx`. If the receive command did not pass the filter, the pair command starts no capture. `rt2rt`=1 only while `capture`=1.
- R7: If either command of a pair addresses the terminal, `yield_rt` is set and `capture` and `rt2rt` are cleared.
- R8: `mode_code` is set when the subaddress (bits 9..5) is 00000 in revision A (`rev_a`=1), and when it is 00000 or 11111 in revision B.
- R9: `data_words` gives the expected data word count. It is 0 for a revision-A mode code. For a revision-B mode code it is 1 when bit 4 is set and 0 otherwise. For any other command it is bits 4..0, with 0 meaning 32.
- R10: `resp_limit` is 9 (µs) when `rev_a`=1 and 15 when `rev_a`=0.
- R11: `msg_end` clears `capture`, `yield_rt` and `rt2rt` on the next cycle. An accepted command in the same cycle takes precedence over it.
- R12: After reset, every output register is 0, including `capture` and `yield_rt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe for a validated command word |
| cmd_pair | input | 1 | Word is the transmit half of a terminal-to-terminal pair |
| cmd_bus_a | input | 1 | 1 if the word came on bus A, 0 for bus B |
| cmd_word | input | 16 | Command word |
| msg_end | input | 1 | Pulse at the end of the current message |
| sel_only | input | 1 | 1 = watch only the masked addresses |
| filt_hi | input | 16 | Mask for addresses 31..16 |
| filt_lo | input | 16 | Mask for addresses 15..0 |
| bcast_en | input | 1 | Treat address 31 as broadcast |
| rev_a | input | 1 | 1 = protocol revision A, 0 = revision B |
| rt_en | input | 1 | Co-resident terminal present |
| rt_addr | input | 5 | Co-resident terminal address |
| capture | output | 1 | Monitor is capturing the current message |
| yield_rt | output | 1 | Terminal owns the current message |
| rt2rt | output | 1 | Captured message is a terminal-to-terminal pair |
| mode_code | output | 1 | Current command is a mode code |
| bcast | output | 1 | Current command is a broadcast |
| bus_a | output | 1 | Bus tag of the current command |
| data_words | output | 6 | Expected data word count |
| cmd_rx | output | 16 | First command of the current message |
| cmd_tx | output | 16 | Stored second command of a pair |
| resp_limit | output | TW | Response time-out limit in µs |

## Verification
Two events can fall in the same cycle: the end of a message and the start of the next one. A message-end pulse can come together with a new command, or together with a command that the terminal ignores because it is busy. The bench provokes both on purpose, and random stimulus raises both pulses independently. In the first case the new command must win. In the second case the release must still happen. The pre-emption of a capture in progress by a terminal command on the other bus is judged the same way, by comparing the outputs one cycle later against an independent model.

// File: rtl/mon_addr_filter.sv
module mon_addr_filter #(
  parameter int TW   = 5,
  parameter int TO_A = 9,
  parameter int TO_B = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_pair,
  input  logic          cmd_bus_a,
  input  logic [15:0]   cmd_word,
  input  logic          msg_end,
  input  logic          sel_only,
  input  logic [15:0]   filt_hi,
  input  logic [15:0]   filt_lo,
  input  logic          bcast_en,
  input  logic          rev_a,
  input  logic          rt_en,
  input  logic [4:0]    rt_addr,
  output logic          capture,
  output logic          yield_rt,
  output logic          rt2rt,
  output logic          mode_code,
  output logic          bcast,
  output logic          bus_a,
  output logic [5:0]    data_words,
  output logic [15:0]   cmd_rx,
  output logic [15:0]   cmd_tx,
  output logic [TW-1:0] resp_limit
);
  typedef enum logic [1:0] {S_IDLE, S_MON, S_RT} st_t;
  st_t st;

  wire [4:0]  addr = cmd_word[15:11];
  wire [4:0]  sa   = cmd_word[9:5];
  wire [4:0]  wc   = cmd_word[4:0];
  wire [31:0] mask = {filt_hi, filt_lo};

  wire is_bc  = bcast_en && (&addr);
  wire hit_rt = rt_en && (addr == rt_addr) && !is_bc;
  wire pass   = !hit_rt && (is_bc || !sel_only || mask[addr]);
  wire is_mc  = rev_a ? (sa == 5'd0) : ((sa == 5'd0) || (&sa));
  wire [5:0] nwords = is_mc ? (rev_a ? 6'd0 : {5'd0, wc[4]})
                            : ((wc == 5'd0) ? 6'd32 : {1'b0, wc});

  wire take1 = cmd_valid && !cmd_pair && (st != S_RT);
  wire take2 = cmd_valid && cmd_pair && (st != S_RT) && (hit_rt || st == S_MON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      rt2rt      <= 1'b0;
      mode_code  <= 1'b0;
      bcast      <= 1'b0;
      bus_a      <= 1'b0;
      data_words <= '0;
      cmd_rx     <= '0;
      cmd_tx     <= '0;
    end else if (take1) begin
      cmd_rx     <= cmd_word;
      bus_a      <= cmd_bus_a;
      mode_code  <= is_mc;
      bcast      <= is_bc;
      data_words <= nwords;
      rt2rt      <= 1'b0;
      cmd_tx     <= '0;
      st         <= hit_rt ? S_RT : (pass ? S_MON : S_IDLE);
    end else if (take2) begin
      if (hit_rt) begin
        st    <= S_RT;
        rt2rt <= 1'b0;
      end else begin
        rt2rt  <= 1'b1;
        cmd_tx <= cmd_word;
      end
    end else if (msg_end) begin
      st    <= S_IDLE;
      rt2rt <= 1'b0;
    end
  end

  assign capture    = (st == S_MON);
  assign yield_rt   = (st == S_RT);
  assign resp_limit = rev_a ? TW'(TO_A) : TW'(TO_B);
endmodule

// File: rtl/mon_addr_filter_chk.sv
module mon_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_pair,
  input logic [15:0] cmd_word,
  input logic        msg_end,
  input logic        sel_only,
  input logic [15:0] filt_hi,
  input logic [15:0] filt_lo,
  input logic        bcast_en,
  input logic        rt_en,
  input logic [4:0]  rt_addr,
  input logic        capture,
  input logic        yield_rt,
  input logic        rt2rt,
  input logic        mode_code,
  input logic [5:0]  data_words
);
  wire [4:0]  a    = cmd_word[15:11];
  wire [31:0] m    = {filt_hi, filt_lo};
  wire        bc31 = bcast_en && (a == 5'd31);

  assert_rt_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_pair && !yield_rt && rt_en && a == rt_addr && !bc31
    |=> yield_rt && !capture);

  assert_rt_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    yield_rt && !msg_end |=> yield_rt && !capture);

  assert_filter_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_pair && !yield_rt && sel_only && !m[a] && !bc31 |=> !capture);

  assert_pair_in_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rt2rt |-> capture);

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end && !cmd_valid |=> !capture && !yield_rt && !rt2rt);

  assert_mc_words_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code |-> data_words <= 6'd1);
endmodule

bind mon_addr_filter mon_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pair(cmd_pair),
  .cmd_word(cmd_word), .msg_end(msg_end), .sel_only(sel_only),
  .filt_hi(filt_hi), .filt_lo(filt_lo), .bcast_en(bcast_en), .rt_en(rt_en),
  .rt_addr(rt_addr), .capture(capture), .yield_rt(yield_rt), .rt2rt(rt2rt),
  .mode_code(mode_code), .data_words(data_words)
);

// File: tb/mon_addr_filter_tb.sv
`timescale 1ns/1ps
module mon_addr_filter_tb;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_pair = 0, cmd_bus_a = 0, msg_end = 0;
  logic [15:0] cmd_word = 0;
  logic sel_only = 0, bcast_en = 0, rev_a = 0, rt_en = 0;
  logic [15:0] filt_hi = 0, filt_lo = 0;
  logic [4:0] rt_addr = 0;
  logic capture, yield_rt, rt2rt, mode_code, bcast, bus_a;
  logic [5:0] data_words;
  logic [15:0] cmd_rx, cmd_tx;
  logic [4:0] resp_limit;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state: 0 idle, 1 capturing, 2 terminal
  int m_st = 0;
  bit m_rr = 0, m_mc = 0, m_bc = 0, m_bus = 0;
  logic [5:0] m_w = 0;
  logic [15:0] m_rx = 0, m_tx = 0;

  always #5 clk = ~clk;

  mon_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pair(cmd_pair),
    .cmd_bus_a(cmd_bus_a), .cmd_word(cmd_word), .msg_end(msg_end),
    .sel_only(sel_only), .filt_hi(filt_hi), .filt_lo(filt_lo),
    .bcast_en(bcast_en), .rev_a(rev_a), .rt_en(rt_en), .rt_addr(rt_addr),
    .capture(capture), .yield_rt(yield_rt), .rt2rt(rt2rt),
    .mode_code(mode_code), .bcast(bcast), .bus_a(bus_a),
    .data_words(data_words), .cmd_rx(cmd_rx), .cmd_tx(cmd_tx),
    .resp_limit(resp_limit));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int a, int tr, int sa, int wc);
    return {a[4:0], tr[0], sa[4:0], wc[4:0]};
  endfunction

  function automatic bit f_bc(logic [15:0] w);
    return bcast_en && (w[15:11] == 5'd31);
  endfunction
  function automatic bit f_rt(logic [15:0] w);
    return rt_en && (w[15:11] == rt_addr) && !f_bc(w);
  endfunction
  function automatic bit f_pass(logic [15:0] w);
    logic [31:0] m;
    m = {filt_hi, filt_lo};
    if (f_rt(w)) return 0;
    if (f_bc(w) || !sel_only) return 1;
    return m[w[15:11]];
  endfunction
  function automatic bit f_mc(logic [15:0] w);
    if (rev_a) return w[9:5] == 5'd0;
    return (w[9:5] == 5'd0) || (w[9:5] == 5'd31);
  endfunction
  function automatic logic [5:0] f_words(logic [15:0] w);
    if (f_mc(w)) return (rev_a || w[4:0] < 16) ? 6'd0 : 6'd1;
    return (w[4:0] == 0) ? 6'd32 : {1'b0, w[4:0]};
  endfunction

  task automatic model_update();
    if (cmd_valid && !cmd_pair && m_st != 2) begin
      m_rx = cmd_word; m_bus = cmd_bus_a; m_mc = f_mc(cmd_word);
      m_bc = f_bc(cmd_word); m_w = f_words(cmd_word); m_rr = 0; m_tx = 0;
      m_st = f_rt(cmd_word) ? 2 : (f_pass(cmd_word) ? 1 : 0);
    end else if (cmd_valid && cmd_pair && m_st != 2 && f_rt(cmd_word)) begin
      m_st = 2; m_rr = 0;
    end else if (cmd_valid && cmd_pair && m_st == 1) begin
      m_rr = 1; m_tx = cmd_word;
    end else if (msg_end) begin
      m_st = 0; m_rr = 0;
    end
  endtask

  task automatic step(bit v, bit pr, bit ba, logic [15:0] w, bit e);
    cmd_valid = v; cmd_pair = pr; cmd_bus_a = ba; cmd_word = w; msg_end = e;
    model_update();
    @(negedge clk);
    cmd_valid = 0; cmd_pair = 0; msg_end = 0;
    chk("R2 capture", capture, m_st == 1);
    chk("R4 yield_rt", yield_rt, m_st == 2);
    chk("R6 rt2rt", rt2rt, m_rr);
    chk("R6 cmd_tx", cmd_tx, m_tx);
    chk("R8 mode_code", mode_code, m_mc);
    chk("R3 bcast", bcast, m_bc);
    chk("R9 data_words", data_words, m_w);
    chk("R1 cmd_rx/bus", {cmd_rx, bus_a}, {m_rx, m_bus});
    chk("R10 resp_limit", resp_limit, rev_a ? 9 : 15);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (R12 run) actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset", {capture, yield_rt, rt2rt, mode_code, bcast, bus_a}, 0);
    chk("R12 reset words", {data_words, cmd_rx, cmd_tx}, 0);

    rt_en = 1; rt_addr = 1;
    step(1, 0, 1, mk(5, 0, 3, 4), 0);
    chk("R1 all-mode capture", capture, 1);

    sel_only = 1; filt_lo = 16'h0008; filt_hi = 16'h0010;
    step(1, 0, 1, mk(3, 0, 3, 4), 0);  chk("R2 low mask hit", capture, 1);
    step(1, 0, 1, mk(4, 0, 3, 4), 0);  chk("R2 low mask miss", capture, 0);
    step(1, 0, 0, mk(20, 0, 3, 4), 0); chk("R2 high mask hit", capture, 1);

    bcast_en = 1;
    step(1, 0, 1, mk(31, 0, 3, 4), 0);
    chk("R3 broadcast captured", {capture, bcast}, 2'b11);
    bcast_en = 0;
    step(1, 0, 1, mk(31, 0, 3, 4), 0);
    chk("R3 addr31 ordinary", {capture, bcast}, 2'b00);

    step(1, 0, 1, mk(20, 0, 3, 4), 0);
    step(1, 0, 0, mk(1, 0, 3, 4), 0);
    chk("R4 preempt on other bus", {capture, yield_rt}, 2'b01);
    step(1, 0, 1, mk(20, 0, 3, 4), 0);
    chk("R5 busy ignores", {capture, yield_rt, bus_a}, 3'b010);
    step(1, 0, 1, mk(20, 0, 3, 4), 1);
    chk("R11 release with ignored cmd", {capture, yield_rt}, 2'b00);

    step(1, 0, 1, mk(3, 0, 3, 4), 0);
    step(1, 1, 1, mk(7, 1, 3, 4), 0);
    chk("R6 pair flagged", {capture, rt2rt}, 2'b11);
    chk("R6 pair kept", cmd_tx, mk(7, 1, 3, 4));
    step(0, 0, 0, 0, 1);
    chk("R11 release", {capture, rt2rt}, 2'b00);
    step(1, 0, 1, mk(9, 0, 3, 4), 0);
    step(1, 1, 1, mk(3, 1, 3, 4), 0);
    chk("R6 rx not filtered", {capture, rt2rt}, 2'b00);
    step(1, 0, 1, mk(3, 0, 3, 4), 0);
    step(1, 1, 1, mk(1, 1, 3, 4), 0);
    chk("R7 tx to terminal", {capture, yield_rt, rt2rt}, 3'b010);
    step(0, 0, 0, 0, 1);

    rev_a = 1;
    step(1, 0, 1, mk(3, 1, 0, 17), 0);
    chk("R8 revA sa0", {mode_code, data_words}, {1'b1, 6'd0});
    step(1, 0, 1, mk(3, 1, 31, 0), 0);
    chk("R9 revA sa31 wc0", {mode_code, data_words}, {1'b0, 6'd32});
    chk("R10 revA limit", resp_limit, 9);
    rev_a = 0;
    step(1, 0, 1, mk(3, 1, 31, 17), 0);
    chk("R9 revB mc data", {mode_code, data_words}, {1'b1, 6'd1});
    step(1, 0, 1, mk(3, 1, 31, 3), 0);
    chk("R8 revB mc no data", {mode_code, data_words}, {1'b1, 6'd0});
    chk("R10 revB limit", resp_limit, 15);
    step(1, 0, 0, mk(20, 0, 2, 5), 1);
    chk("R11 command beats end", {capture, data_words}, {1'b1, 6'd5});

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      int r;
      if ($urandom_range(0, 15) == 0) begin
        sel_only = $urandom_range(0, 1); bcast_en = $urandom_range(0, 1);
        rev_a = $urandom_range(0, 1); rt_en = $urandom_range(0, 1);
        rt_addr = 5'($urandom_range(0, 31));
        filt_hi = 16'($urandom); filt_lo = 16'($urandom);
      end
      w = 16'($urandom);
      r = $urandom_range(0, 9);
      if (r == 0) w[15:11] = rt_addr;
      else if (r == 1) w[15:11] = 5'd31;
      if ($urandom_range(0, 3) == 0) w[9:5] = $urandom_range(0, 1) ? 5'd0 : 5'd31;
      step($urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 1), w, $urandom_range(0, 3) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule